// File: doc/BRIEF.md
# Descriptor SRAM Init Sequencer

This block owns a small on-chip descriptor SRAM (256 bytes by default) and fills it on command. A reload fetches every byte from an external nonvolatile memory over a byte-wide request/response stream pair and writes each byte to the SRAM address it came from. A wipe writes zero to every address instead. Three control bits drive it: a start bit, a wipe qualifier and a lock bit that shuts the external display-data read port out of the SRAM.

The start and wipe bits are written through a plain write strobe. They read back as 1 while the operation runs and return to 0 by themselves when it ends. The lock bit comes up from a strap pin at reset and can be changed by any later write. The serial protocol toward the nonvolatile memory sits outside this block. The block only sees a request stream that carries an address and a response stream that carries a data byte.

Back-pressure rules: a request, once valid, keeps its address until `nv_req_ready` is seen high at a clock edge. Only one request is outstanding at a time. `nv_rsp_ready` is high only while the block waits for the byte it asked for, so the responder may hold `nv_rsp_valid` for as long as it needs. On the read port, `ext_rd_ready` tells the requester whether a read is accepted in that cycle. The response has no back-pressure: its data arrives exactly one cycle after acceptance.

Top module: `desc_sram_seq`

## Requirements
- R1: During and after reset `stat_lock` equals `strap_lock`, while `stat_start`, `stat_wipe` and `busy` are 0.
- R2: A write with `cfg_start`=1 and `cfg_wipe`=0 while idle issues requests for addresses 0,1,…,DEPTH-1 in ascending order, exactly once each. Each returned byte is stored at the address it was requested for.
- R3: A write with `cfg_start`=1 and `cfg_wipe`=1 while idle writes 0 to every address, one address per cycle. It keeps `busy` high for exactly DEPTH cycles and issues no request.
- R4: A write with `cfg_wipe`=1 and `cfg_start`=0 has no effect: `busy` and `stat_wipe` stay 0 and the SRAM contents are unchanged.
- R5: `stat_start` (and `stat_wipe` for a wipe) is 1 from the cycle after the accepted write until the operation ends, then clears by itself.
- R6: While `stat_lock` is 1, `ext_rd_ready` is 0.
- R7: While `busy` is 1, `ext_rd_ready` is 0.
- R8: Start or wipe writes that arrive while busy are ignored: the running operation neither restarts nor changes kind.
- R9: A valid request holds its address stable until it is accepted. At most one request is outstanding, and `nv_rsp_ready` is high only while waiting for that byte.
- R10: A read accepted on the external port returns `ext_rsp_valid`=1 with the SRAM byte at `ext_rd_addr` in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strap_lock | input | 1 | Reset value of the lock bit |
| cfg_we | input | 1 | Control write strobe |
| cfg_start | input | 1 | Start bit of the write |
| cfg_wipe | input | 1 | Wipe qualifier of the write |
| cfg_lock | input | 1 | Lock bit of the write |
| stat_start | output | 1 | Start bit readback |
| stat_wipe | output | 1 | Wipe bit readback |
| stat_lock | output | 1 | Lock bit readback |
| busy | output | 1 | Operation in progress |
| nv_req_valid | output | 1 | Request stream valid |
| nv_req_ready | input | 1 | Request stream ready |
| nv_req_addr | output | ADDR_W | Requested byte address |
| nv_rsp_valid | input | 1 | Response stream valid |
| nv_rsp_ready | output | 1 | Response stream ready |
| nv_rsp_data | input | DATA_W | Returned byte |
| ext_rd_valid | input | 1 | External read request |
| ext_rd_ready | output | 1 | External read accepted |
| ext_rd_addr | input | ADDR_W | External read address |
| ext_rsp_valid | output | 1 | External read data valid |
| ext_rsp_data | output | DATA_W | External read data |

## Verification
On every cycle the assertions check the rules that need no knowledge of the SRAM contents. These are the port shut-off under lock or busy, the stability of a stalled request, the rule that wipes never touch the request stream, the pairing of the wipe bit with the start bit, and the one-cycle read response. The stored contents, the ascending order of fetches, the exact wipe duration and the ignoring of stray or late commands can only be shown by the bench scenarios. These scenarios read every address back through the external port after each reload, wipe and ignored command, and compare against arithmetically generated bytes.

// File: rtl/desc_seq_pkg.sv
package desc_seq_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WIPE = 2'd1,
    ST_REQ  = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_e;
endpackage

// File: rtl/desc_seq_ctrl.sv
module desc_seq_ctrl
  import desc_seq_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_lock,
  input  logic              cfg_we,
  input  logic              cfg_start,
  input  logic              cfg_wipe,
  input  logic              cfg_lock,
  output logic              stat_start,
  output logic              stat_wipe,
  output logic              stat_lock,
  output logic              busy,
  output logic              nv_req_valid,
  input  logic              nv_req_ready,
  output logic [ADDR_W-1:0] nv_req_addr,
  input  logic              nv_rsp_valid,
  output logic              nv_rsp_ready,
  input  logic [DATA_W-1:0] nv_rsp_data,
  output logic              wr_en,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data
);
  localparam logic [ADDR_W-1:0] LAST_ADDR = {ADDR_W{1'b1}};

  seq_state_e        state_q;
  logic [ADDR_W-1:0] addr_q;
  logic              start_q, wipe_q, lock_q;
  logic              at_last;

  assign at_last = (addr_q == LAST_ADDR);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      addr_q  <= '0;
      start_q <= 1'b0;
      wipe_q  <= 1'b0;
      lock_q  <= strap_lock;
    end else begin
      if (cfg_we) lock_q <= cfg_lock;
      unique case (state_q)
        ST_IDLE: begin
          if (cfg_we && cfg_start) begin
            start_q <= 1'b1;
            wipe_q  <= cfg_wipe;
            addr_q  <= '0;
            state_q <= cfg_wipe ? ST_WIPE : ST_REQ;
          end
        end
        ST_WIPE: begin
          addr_q <= addr_q + 1'b1;
          if (at_last) begin
            state_q <= ST_IDLE;
            start_q <= 1'b0;
            wipe_q  <= 1'b0;
          end
        end
        ST_REQ: begin
          if (nv_req_ready) state_q <= ST_WAIT;
        end
        ST_WAIT: begin
          if (nv_rsp_valid) begin
            if (at_last) begin
              state_q <= ST_IDLE;
              start_q <= 1'b0;
              wipe_q  <= 1'b0;
            end else begin
              addr_q  <= addr_q + 1'b1;
              state_q <= ST_REQ;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  always_comb begin
    nv_req_valid = (state_q == ST_REQ);
    nv_rsp_ready = (state_q == ST_WAIT);
    nv_req_addr  = addr_q;
    wr_en        = (state_q == ST_WIPE) || ((state_q == ST_WAIT) && nv_rsp_valid);
    wr_addr      = addr_q;
    wr_data      = (state_q == ST_WIPE) ? '0 : nv_rsp_data;
  end

  assign busy       = (state_q != ST_IDLE);
  assign stat_start = start_q;
  assign stat_wipe  = wipe_q;
  assign stat_lock  = lock_q;
endmodule

// File: rtl/desc_seq_mem.sv
module desc_seq_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
    if (rd_en) rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/desc_seq_gate.sv
module desc_seq_gate #(
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lock,
  input  logic              busy,
  input  logic              ext_rd_valid,
  output logic              ext_rd_ready,
  input  logic [ADDR_W-1:0] ext_rd_addr,
  output logic              ext_rsp_valid,
  output logic              rd_en,
  output logic [ADDR_W-1:0] rd_addr
);
  logic rsp_q;

  assign ext_rd_ready = !lock && !busy;
  assign rd_en        = ext_rd_valid && ext_rd_ready;
  assign rd_addr      = ext_rd_addr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsp_q <= 1'b0;
    else        rsp_q <= rd_en;
  end

  assign ext_rsp_valid = rsp_q;
endmodule

// File: rtl/desc_sram_seq.sv
module desc_sram_seq #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              strap_lock,
  input  logic              cfg_we,
  input  logic              cfg_start,
  input  logic              cfg_wipe,
  input  logic              cfg_lock,
  output logic              stat_start,
  output logic              stat_wipe,
  output logic              stat_lock,
  output logic              busy,
  output logic              nv_req_valid,
  input  logic              nv_req_ready,
  output logic [ADDR_W-1:0] nv_req_addr,
  input  logic              nv_rsp_valid,
  output logic              nv_rsp_ready,
  input  logic [DATA_W-1:0] nv_rsp_data,
  input  logic              ext_rd_valid,
  output logic              ext_rd_ready,
  input  logic [ADDR_W-1:0] ext_rd_addr,
  output logic              ext_rsp_valid,
  output logic [DATA_W-1:0] ext_rsp_data
);
  logic              wr_en, rd_en;
  logic [ADDR_W-1:0] wr_addr, rd_addr;
  logic [DATA_W-1:0] wr_data;

  desc_seq_ctrl #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .strap_lock(strap_lock),
    .cfg_we(cfg_we), .cfg_start(cfg_start), .cfg_wipe(cfg_wipe), .cfg_lock(cfg_lock),
    .stat_start(stat_start), .stat_wipe(stat_wipe), .stat_lock(stat_lock), .busy(busy),
    .nv_req_valid(nv_req_valid), .nv_req_ready(nv_req_ready), .nv_req_addr(nv_req_addr),
    .nv_rsp_valid(nv_rsp_valid), .nv_rsp_ready(nv_rsp_ready), .nv_rsp_data(nv_rsp_data),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data)
  );

  desc_seq_gate #(.ADDR_W(ADDR_W)) u_gate (
    .clk(clk), .rst_n(rst_n), .lock(stat_lock), .busy(busy),
    .ext_rd_valid(ext_rd_valid), .ext_rd_ready(ext_rd_ready), .ext_rd_addr(ext_rd_addr),
    .ext_rsp_valid(ext_rsp_valid), .rd_en(rd_en), .rd_addr(rd_addr)
  );

  desc_seq_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(ext_rsp_data)
  );
endmodule

// File: rtl/desc_sram_seq_chk.sv
module desc_sram_seq_chk #(
  parameter int ADDR_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              stat_start,
  input logic              stat_wipe,
  input logic              stat_lock,
  input logic              nv_req_valid,
  input logic              nv_req_ready,
  input logic [ADDR_W-1:0] nv_req_addr,
  input logic              nv_rsp_ready,
  input logic              ext_rd_valid,
  input logic              ext_rd_ready,
  input logic              ext_rsp_valid
);
  AST_LOCK_SHUTS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    stat_lock |-> !ext_rd_ready); // R6

  AST_BUSY_SHUTS_PORT: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !ext_rd_ready); // R7

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req_valid && !nv_req_ready) |=> (nv_req_valid && $stable(nv_req_addr))); // R9

  AST_ONE_OUTSTANDING: assert property (@(posedge clk) disable iff (!rst_n)
    !(nv_req_valid && nv_rsp_ready)); // R9

  AST_WIPE_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wipe |-> (!nv_req_valid && !nv_rsp_ready)); // R3

  AST_WIPE_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
    stat_wipe |-> stat_start); // R4

  AST_FETCH_ONLY_RUNNING: assert property (@(posedge clk) disable iff (!rst_n)
    (nv_req_valid || nv_rsp_ready) |-> (busy && stat_start)); // R5

  AST_READ_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (ext_rd_valid && ext_rd_ready) |=> ext_rsp_valid); // R10
endmodule

bind desc_sram_seq desc_sram_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .stat_start(stat_start),
  .stat_wipe(stat_wipe), .stat_lock(stat_lock), .nv_req_valid(nv_req_valid),
  .nv_req_ready(nv_req_ready), .nv_req_addr(nv_req_addr), .nv_rsp_ready(nv_rsp_ready),
  .ext_rd_valid(ext_rd_valid), .ext_rd_ready(ext_rd_ready), .ext_rsp_valid(ext_rsp_valid)
);

// File: tb/desc_sram_seq_tb.sv
module desc_sram_seq_tb;
  localparam int ADDR_W = 8;
  localparam int DATA_W = 8;
  localparam int DEPTH  = 1 << ADDR_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic strap_lock = 1'b1;
  logic cfg_we = 1'b0, cfg_start = 1'b0, cfg_wipe = 1'b0, cfg_lock = 1'b0;
  logic stat_start, stat_wipe, stat_lock, busy;
  logic nv_req_valid, nv_req_ready, nv_rsp_valid, nv_rsp_ready;
  logic [ADDR_W-1:0] nv_req_addr;
  logic [DATA_W-1:0] nv_rsp_data;
  logic ext_rd_valid = 1'b0;
  logic ext_rd_ready, ext_rsp_valid;
  logic [ADDR_W-1:0] ext_rd_addr = '0;
  logic [DATA_W-1:0] ext_rsp_data;

  int checks = 0, errors = 0;
  bit finished = 0;

  // nonvolatile memory model state
  bit stall = 0;
  logic [7:0] seed = 8'h00;
  bit pend = 0;
  logic [ADDR_W-1:0] paddr = '0;
  int cyc = 0;
  bit mon_clr = 0;
  int req_cnt = 0, order_err = 0;
  logic [ADDR_W-1:0] exp_next = '0;

  always #2.5 clk = ~clk;

  desc_sram_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_dut (
    .clk(clk), .rst_n(rst_n), .strap_lock(strap_lock),
    .cfg_we(cfg_we), .cfg_start(cfg_start), .cfg_wipe(cfg_wipe), .cfg_lock(cfg_lock),
    .stat_start(stat_start), .stat_wipe(stat_wipe), .stat_lock(stat_lock), .busy(busy),
    .nv_req_valid(nv_req_valid), .nv_req_ready(nv_req_ready), .nv_req_addr(nv_req_addr),
    .nv_rsp_valid(nv_rsp_valid), .nv_rsp_ready(nv_rsp_ready), .nv_rsp_data(nv_rsp_data),
    .ext_rd_valid(ext_rd_valid), .ext_rd_ready(ext_rd_ready), .ext_rd_addr(ext_rd_addr),
    .ext_rsp_valid(ext_rsp_valid), .ext_rsp_data(ext_rsp_data)
  );

  function automatic logic [7:0] nv_byte(input int a, input logic [7:0] s);
    return 8'((a * 37) + s);
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (mon_clr) begin
      req_cnt <= 0; order_err <= 0; exp_next <= '0; pend <= 1'b0;
    end else begin
      if (nv_rsp_valid && nv_rsp_ready) pend <= 1'b0;
      if (nv_req_valid && nv_req_ready) begin
        pend <= 1'b1;
        paddr <= nv_req_addr;
        if (nv_req_addr != exp_next) order_err <= order_err + 1;
        exp_next <= exp_next + 1'b1;
        req_cnt <= req_cnt + 1;
      end
    end
  end

  always @(negedge clk) begin
    nv_req_ready <= stall ? (cyc % 3 == 2) : 1'b1;
    nv_rsp_valid <= pend && (stall ? (cyc % 2 == 0) : 1'b1);
    nv_rsp_data  <= nv_byte(int'(paddr), seed);
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic cfg_write(input bit s, input bit w, input bit l);
    cfg_we = 1'b1; cfg_start = s; cfg_wipe = w; cfg_lock = l;
    @(negedge clk);
    cfg_we = 1'b0; cfg_start = 1'b0; cfg_wipe = 1'b0;
  endtask

  task automatic wait_idle(output int n);
    n = 0;
    while (busy && n < 5000) begin @(negedge clk); n++; end
  endtask

  // zero_exp=1 expects all zeros, else nv_byte(a, s)
  task automatic sweep(input bit zero_exp, input logic [7:0] s, input string req);
    int bad = 0, fa = -1, fv = 0, fe = 0;
    for (int a = 0; a < DEPTH; a++) begin
      int e;
      e = zero_exp ? 0 : int'(nv_byte(a, s));
      ext_rd_valid = 1'b1; ext_rd_addr = ADDR_W'(a);
      @(negedge clk);
      ext_rd_valid = 1'b0;
      if (!ext_rsp_valid || int'(ext_rsp_data) != e) begin
        bad++;
        if (fa < 0) begin fa = a; fv = int'(ext_rsp_data); fe = e; end
      end
    end
    check(bad == 0, req, fv, fe);
  endtask

  initial begin
    int n;
    // R1: reset with strap high
    repeat (3) @(negedge clk);
    check(stat_lock == 1'b1, "R1 lock from strap=1", stat_lock, 1);
    rst_n = 1'b1;
    @(negedge clk);
    check(stat_lock == 1'b1 && !busy && !stat_start && !stat_wipe, "R1 post-reset state",
          {stat_lock, busy, stat_start, stat_wipe}, 4'b1000);
    check(ext_rd_ready == 1'b0, "R6 locked port refuses", ext_rd_ready, 0);
    // R1: reset with strap low
    rst_n = 1'b0; strap_lock = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(stat_lock == 1'b0 && ext_rd_ready, "R1 lock from strap=0", stat_lock, 0);

    // R2, R5: plain reload, no stalls
    stall = 0; seed = 8'h11; mon_clr = 1; @(negedge clk); mon_clr = 0;
    cfg_write(1, 0, 0);
    check(busy && stat_start && !stat_wipe, "R5 start bit set during reload",
          {busy, stat_start, stat_wipe}, 3'b110);
    wait_idle(n);
    check(!stat_start && !stat_wipe, "R5 bits self-clear after reload", stat_start, 0);
    check(req_cnt == DEPTH && order_err == 0, "R2 ascending fetch count", req_cnt, DEPTH);
    sweep(0, 8'h11, "R2 R10 contents after reload");

    // R4: wipe without start is ignored
    cfg_write(0, 1, 0);
    check(!busy && !stat_wipe, "R4 lone wipe ignored", {busy, stat_wipe}, 0);
    sweep(0, 8'h11, "R4 contents unchanged");

    // R3, R5: start+wipe
    mon_clr = 1; @(negedge clk); mon_clr = 0;
    cfg_write(1, 1, 0);
    check(stat_start && stat_wipe, "R5 both bits set during wipe", {stat_start, stat_wipe}, 3);
    check(ext_rd_ready == 1'b0, "R7 port refused while busy", ext_rd_ready, 0);
    wait_idle(n);
    check(n == DEPTH, "R3 wipe duration", n, DEPTH);
    check(req_cnt == 0, "R3 no fetch during wipe", req_cnt, 0);
    check(!stat_start && !stat_wipe, "R5 bits self-clear after wipe", stat_wipe, 0);
    sweep(1, 8'h00, "R3 contents zero");

    // R8, R9: stalled reload with a wipe command arriving mid-run
    stall = 1; seed = 8'hA5; mon_clr = 1; @(negedge clk); mon_clr = 0;
    cfg_write(1, 0, 0);
    repeat (20) @(negedge clk);
    cfg_write(1, 1, 0);
    check(busy && !stat_wipe, "R8 late wipe ignored", stat_wipe, 0);
    check(ext_rd_ready == 1'b0, "R7 port refused mid-reload", ext_rd_ready, 0);
    wait_idle(n);
    check(req_cnt == DEPTH && order_err == 0, "R9 stalled fetch order", order_err, 0);
    sweep(0, 8'hA5, "R8 R9 contents after stalled reload");

    // R6: lock by write
    cfg_write(0, 0, 1);
    check(stat_lock && !ext_rd_ready, "R6 lock written", ext_rd_ready, 0);
    cfg_write(0, 0, 0);
    check(!stat_lock && ext_rd_ready, "R6 unlock written", ext_rd_ready, 1);

    if (!finished) begin
      finished = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule